// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that runs on its own slow clock, apart from the bus clock that software uses to reach it. It has four word-addressed registers on a simple write/read port. A key register accepts command words. A divider-select register and a reload register hold the timing setup. A status register shows pending transfers. Once the watchdog is launched, a 12-bit counter counts down. It moves one step per divided slow-clock period. If software does not refresh the counter before it reaches zero, the block raises a reset request.

The watchdog can be launched in two ways: by a start key word, or by a hardware strap input that is sampled while the system is in reset and afterwards. After launch it cannot be stopped, and its clock-enable request stays high until the next system reset. The divider and reload settings are guarded by an unlock key. Each accepted setting crosses into the slow domain with a toggle handshake, and a busy flag stays set until the slow domain acknowledges. A debug-freeze enable, combined with a core-halted input, pauses the count.

Top module: `wdg_independent`

## Requirements
- R1: After system reset, the reset output and the clock request output are low. The status register (address 3) reads 0, the divider register (address 1) reads 0, the reload register (address 2) reads 0xFFF, and the key register (address 0) reads 0.
- R2: Writing 0xCCCC to the key register launches the watchdog. The clock request output goes high on the next bus cycle, and the counter starts at 0xFFF.
- R3: When the hardware strap input is high, the watchdog launches with no software write at all.
- R4: Once launched, the clock request output stays high and the watchdog keeps running whatever key words are written afterwards. Only system reset stops it.
- R5: The counter steps down once every 4 << min(code, 6) slow-clock cycles, where code is the 3-bit divider value. Codes 6 and 7 both divide by 256.
- R6: When a running counter holds zero, the reset output goes high on the next slow-clock edge. It then stays high until system reset, even if refresh keys are written.
- R7: Writing 0xAAAA to the key register while running loads the counter from the reload value and clears the divider phase. A refresh that arrives in the same slow-clock cycle as a step-down takes priority over it.
- R8: Writes to the divider and reload registers take effect only if the most recent key word was 0x5555. Writing any other key word removes that access.
- R9: Status bit 0 (divider) and bit 1 (reload) read 1 from the cycle after an accepted write until the slow domain acknowledges the write. A write to a register whose flag is set is ignored.
- R10: While the freeze-enable input and the core-halted input are both high, the counter holds its value. With either input low, counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset, both domains |
| wd_clk | input | 1 | Slow watchdog clock |
| hw_start_i | input | 1 | Hardware strap that launches the watchdog |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 key, 1 divider, 2 reload, 3 status |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read address, same map as the write address |
| rd_data_o | output | 16 | Read data, combinational from rd_addr_i |
| freeze_cfg_i | input | 1 | Debug-freeze enable |
| core_halted_i | input | 1 | High while the core is halted |
| clk_req_o | output | 1 | Sticky request to keep the slow clock running |
| wd_reset_o | output | 1 | Sticky watchdog reset request |

## Verification
Two functions can fall in the same slow-clock cycle: an accepted refresh and a prescaler-tick step-down. The refresh must win, so the counter ends on the reload value and not one below it. The bench provokes this by refreshing over and over at spacings that sweep across multiples of the divider period. Because every refresh also realigns the divider phase, some refreshes land exactly on a tick. The outcome is judged by a property that compares the counter with the prior reload value after every accepted refresh, and by the reset output staying low throughout the sweep.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int WDG_ADDR_W = 2;
    localparam int WDG_KEY_W  = 16;

    localparam logic [WDG_KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [WDG_KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [WDG_KEY_W-1:0] KEY_UNLOCK  = 16'h5555;

    typedef enum logic [WDG_ADDR_W-1:0] {
        ADDR_KEY    = 2'd0,
        ADDR_DIV    = 2'd1,
        ADDR_RELOAD = 2'd2,
        ADDR_STAT   = 2'd3
    } wdg_addr_e;
endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdg_bus_regs.sv
module wdg_bus_regs
    import wdg_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int SEL_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_start_i,
    input  logic                  wr_en_i,
    input  logic [WDG_ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [WDG_ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0]     rd_data_o,
    input  logic                  div_ack_tgl_i,
    input  logic                  rld_ack_tgl_i,
    output logic                  started_o,
    output logic                  unlock_o,
    output logic                  refresh_tgl_o,
    output logic                  div_req_tgl_o,
    output logic                  rld_req_tgl_o,
    output logic                  div_busy_o,
    output logic                  rld_busy_o,
    output logic [SEL_W-1:0]      div_val_o,
    output logic [CNT_W-1:0]      rld_val_o
);
    typedef struct packed {
        logic             started;
        logic             unlock;
        logic             refresh_tgl;
        logic             div_req_tgl;
        logic             rld_req_tgl;
        logic [SEL_W-1:0] div_val;
        logic [CNT_W-1:0] rld_val;
    } bus_state_t;

    bus_state_t state_d, state_q;
    logic       div_busy, rld_busy;
    wdg_addr_e  wr_sel, rd_sel;
    logic [WDG_KEY_W-1:0] key_word;

    assign div_busy = state_q.div_req_tgl ^ div_ack_tgl_i;
    assign rld_busy = state_q.rld_req_tgl ^ rld_ack_tgl_i;
    assign wr_sel   = wdg_addr_e'(wr_addr_i);
    assign rd_sel   = wdg_addr_e'(rd_addr_i);
    assign key_word = wr_data_i[WDG_KEY_W-1:0];

    always_comb begin
        state_d = state_q;
        if (hw_start_i) state_d.started = 1'b1;
        if (wr_en_i) begin
            case (wr_sel)
                ADDR_KEY: begin
                    state_d.unlock = (key_word == KEY_UNLOCK);
                    if (key_word == KEY_START) state_d.started = 1'b1;
                    if (key_word == KEY_REFRESH && state_q.started)
                        state_d.refresh_tgl = ~state_q.refresh_tgl;
                end
                ADDR_DIV: begin
                    if (state_q.unlock && !div_busy) begin
                        state_d.div_val     = wr_data_i[SEL_W-1:0];
                        state_d.div_req_tgl = ~state_q.div_req_tgl;
                    end
                end
                ADDR_RELOAD: begin
                    if (state_q.unlock && !rld_busy) begin
                        state_d.rld_val     = wr_data_i[CNT_W-1:0];
                        state_d.rld_req_tgl = ~state_q.rld_req_tgl;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{started: 1'b0, unlock: 1'b0, refresh_tgl: 1'b0,
                         div_req_tgl: 1'b0, rld_req_tgl: 1'b0,
                         div_val: '0, rld_val: '1};
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (rd_sel)
            ADDR_DIV:    rd_data_o = DATA_W'(state_q.div_val);
            ADDR_RELOAD: rd_data_o = DATA_W'(state_q.rld_val);
            ADDR_STAT:   rd_data_o = DATA_W'({rld_busy, div_busy});
            default:     rd_data_o = '0;
        endcase
    end

    assign started_o     = state_q.started;
    assign unlock_o      = state_q.unlock;
    assign refresh_tgl_o = state_q.refresh_tgl;
    assign div_req_tgl_o = state_q.div_req_tgl;
    assign rld_req_tgl_o = state_q.rld_req_tgl;
    assign div_busy_o    = div_busy;
    assign rld_busy_o    = rld_busy;
    assign div_val_o     = state_q.div_val;
    assign rld_val_o     = state_q.rld_val;
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
    parameter int CNT_W     = 12,
    parameter int SEL_W     = 3,
    parameter int MIN_SHIFT = 2,
    parameter int MAX_SEL   = 6,
    parameter int PRE_W     = MIN_SHIFT + MAX_SEL
) (
    input  logic             wd_clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             refresh_tgl_i,
    input  logic             div_req_tgl_i,
    input  logic             rld_req_tgl_i,
    input  logic [SEL_W-1:0] div_val_i,
    input  logic [CNT_W-1:0] rld_val_i,
    input  logic             freeze_i,
    output logic             div_ack_tgl_o,
    output logic             rld_ack_tgl_o,
    output logic             run_o,
    output logic             refresh_acc_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic             wd_reset_o
);
    typedef struct packed {
        logic             run;
        logic             expired;
        logic             refresh_seen;
        logic             div_seen;
        logic             rld_seen;
        logic [SEL_W-1:0] div_sel;
        logic [CNT_W-1:0] reload;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] count;
    } core_state_t;

    core_state_t      state_d, state_q;
    logic             refresh_req, refresh_acc, run_now;
    logic [SEL_W-1:0] sel_eff;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] pre_last;

    always_comb begin
        sel_eff  = (int'(state_q.div_sel) > MAX_SEL) ? SEL_W'(MAX_SEL) : state_q.div_sel;
        span     = (PRE_W+1)'(1) << (int'(sel_eff) + MIN_SHIFT);
        pre_last = PRE_W'(span - 1'b1);
    end

    always_comb begin
        state_d      = state_q;
        refresh_req  = refresh_tgl_i ^ state_q.refresh_seen;
        run_now      = state_q.run | start_i;
        refresh_acc  = refresh_req & run_now;

        state_d.refresh_seen = refresh_tgl_i;
        state_d.run          = run_now;

        if (div_req_tgl_i != state_q.div_seen) begin
            state_d.div_seen = div_req_tgl_i;
            state_d.div_sel  = div_val_i;
        end
        if (rld_req_tgl_i != state_q.rld_seen) begin
            state_d.rld_seen = rld_req_tgl_i;
            state_d.reload   = rld_val_i;
        end

        if (state_q.run && state_q.count == '0) state_d.expired = 1'b1;

        if (refresh_acc) begin
            state_d.count = state_q.reload;
            state_d.pre   = '0;
        end else if (start_i && !state_q.run) begin
            state_d.count = '1;
            state_d.pre   = '0;
        end else if (state_q.run && !freeze_i && state_q.count != '0) begin
            if (state_q.pre >= pre_last) begin
                state_d.pre   = '0;
                state_d.count = state_q.count - 1'b1;
            end else begin
                state_d.pre = state_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge wd_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{run: 1'b0, expired: 1'b0, refresh_seen: 1'b0,
                         div_seen: 1'b0, rld_seen: 1'b0, div_sel: '0,
                         reload: '1, pre: '0, count: '1};
        end else begin
            state_q <= state_d;
        end
    end

    assign div_ack_tgl_o = state_q.div_seen;
    assign rld_ack_tgl_o = state_q.rld_seen;
    assign run_o         = state_q.run;
    assign refresh_acc_o = refresh_acc;
    assign count_o       = state_q.count;
    assign reload_o      = state_q.reload;
    assign wd_reset_o    = state_q.expired;
endmodule

// File: rtl/wdg_independent.sv
module wdg_independent
    import wdg_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SEL_W       = 3,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_SHIFT   = 2,
    parameter int MAX_SEL     = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wd_clk,
    input  logic                  hw_start_i,
    input  logic                  wr_en_i,
    input  logic [WDG_ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [WDG_ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0]     rd_data_o,
    input  logic                  freeze_cfg_i,
    input  logic                  core_halted_i,
    output logic                  clk_req_o,
    output logic                  wd_reset_o
);
    localparam int PRE_W = MIN_SHIFT + MAX_SEL;

    logic             started_w, unlock_w, refresh_tgl_w;
    logic             div_req_w, rld_req_w, div_busy_w, rld_busy_w;
    logic [SEL_W-1:0] div_val_w;
    logic [CNT_W-1:0] rld_val_w;
    logic [3:0]       to_slow_w;
    logic [1:0]       freeze_sync_w;
    logic [1:0]       ack_slow_w, ack_fast_w;
    logic             frozen_w, core_run_w, refresh_acc_w;
    logic [CNT_W-1:0] core_count_w, core_reload_w;

    wdg_bus_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .hw_start_i    (hw_start_i),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .rd_addr_i     (rd_addr_i),
        .rd_data_o     (rd_data_o),
        .div_ack_tgl_i (ack_fast_w[0]),
        .rld_ack_tgl_i (ack_fast_w[1]),
        .started_o     (started_w),
        .unlock_o      (unlock_w),
        .refresh_tgl_o (refresh_tgl_w),
        .div_req_tgl_o (div_req_w),
        .rld_req_tgl_o (rld_req_w),
        .div_busy_o    (div_busy_w),
        .rld_busy_o    (rld_busy_w),
        .div_val_o     (div_val_w),
        .rld_val_o     (rld_val_w)
    );

    wdg_sync #(.STAGES(SYNC_STAGES), .W(4)) u_sync_cmd (
        .clk   (wd_clk),
        .rst_n (rst_n),
        .d_i   ({rld_req_w, div_req_w, refresh_tgl_w, started_w}),
        .q_o   (to_slow_w)
    );

    wdg_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync_frz (
        .clk   (wd_clk),
        .rst_n (rst_n),
        .d_i   ({core_halted_i, freeze_cfg_i}),
        .q_o   (freeze_sync_w)
    );

    assign frozen_w = freeze_sync_w[0] & freeze_sync_w[1];

    wdg_core #(.CNT_W(CNT_W), .SEL_W(SEL_W), .MIN_SHIFT(MIN_SHIFT),
               .MAX_SEL(MAX_SEL), .PRE_W(PRE_W)) u_core (
        .wd_clk        (wd_clk),
        .rst_n         (rst_n),
        .start_i       (to_slow_w[0]),
        .refresh_tgl_i (to_slow_w[1]),
        .div_req_tgl_i (to_slow_w[2]),
        .rld_req_tgl_i (to_slow_w[3]),
        .div_val_i     (div_val_w),
        .rld_val_i     (rld_val_w),
        .freeze_i      (frozen_w),
        .div_ack_tgl_o (ack_slow_w[0]),
        .rld_ack_tgl_o (ack_slow_w[1]),
        .run_o         (core_run_w),
        .refresh_acc_o (refresh_acc_w),
        .count_o       (core_count_w),
        .reload_o      (core_reload_w),
        .wd_reset_o    (wd_reset_o)
    );

    wdg_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync_ack (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ack_slow_w),
        .q_o   (ack_fast_w)
    );

    assign clk_req_o = started_w;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
    import wdg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int SEL_W = 3
) (
    input logic                  clk,
    input logic                  wd_clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [WDG_ADDR_W-1:0] wr_addr,
    input logic                  unlock,
    input logic                  rld_busy,
    input logic [SEL_W-1:0]      div_val,
    input logic [CNT_W-1:0]      rld_val,
    input logic                  clk_req,
    input logic                  run,
    input logic                  refresh_acc,
    input logic                  frozen,
    input logic [CNT_W-1:0]      count,
    input logic [CNT_W-1:0]      reload,
    input logic                  wd_reset
);
    p_clkreq_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_req |=> clk_req);

    p_locked_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_DIV && !unlock) |=> $stable(div_val));

    p_busy_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_RELOAD && rld_busy) |=> $stable(rld_val));

    p_expire_r6: assert property (@(posedge wd_clk) disable iff (!rst_n)
        (run && count == '0) |=> wd_reset);

    p_reset_sticky_r6: assert property (@(posedge wd_clk) disable iff (!rst_n)
        wd_reset |=> wd_reset);

    p_refresh_wins_r7: assert property (@(posedge wd_clk) disable iff (!rst_n)
        refresh_acc |=> (count == $past(reload)));

    p_step_down_r5: assert property (@(posedge wd_clk) disable iff (!rst_n)
        (run && !refresh_acc) |=> (count == $past(count) || count == $past(count) - 1'b1));

    p_freeze_hold_r10: assert property (@(posedge wd_clk) disable iff (!rst_n)
        (run && frozen && !refresh_acc) |=> $stable(count));
endmodule

bind wdg_independent wdg_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
    .clk         (clk),
    .wd_clk      (wd_clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en_i),
    .wr_addr     (wr_addr_i),
    .unlock      (unlock_w),
    .rld_busy    (rld_busy_w),
    .div_val     (div_val_w),
    .rld_val     (rld_val_w),
    .clk_req     (clk_req_o),
    .run         (core_run_w),
    .refresh_acc (refresh_acc_w),
    .frozen      (frozen_w),
    .count       (core_count_w),
    .reload      (core_reload_w),
    .wd_reset    (wd_reset_o)
);

// File: tb/tb_wdg_independent.sv
module tb_wdg_independent;
    logic        clk = 1'b0;
    logic        wd_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_start = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        freeze_cfg = 1'b0;
    logic        core_halted = 1'b0;
    logic        clk_req;
    logic        wd_reset;

    int checks = 0;
    int failures = 0;
    logic [15:0] rv;

    always #10 clk = ~clk;
    always #35 wd_clk = ~wd_clk;

    wdg_independent dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wd_clk        (wd_clk),
        .hw_start_i    (hw_start),
        .wr_en_i       (wr_en),
        .wr_addr_i     (wr_addr),
        .wr_data_i     (wr_data),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .freeze_cfg_i  (freeze_cfg),
        .core_halted_i (core_halted),
        .clk_req_o     (clk_req),
        .wd_reset_o    (wd_reset)
    );

    localparam int NVEC = 6;
    localparam int VCODE [NVEC] = '{0, 1, 2, 7, 6, 3};
    localparam int VRLD  [NVEC] = '{10, 5, 3, 1, 1, 0};
    localparam int VHALT [NVEC] = '{0, 1, 0, 0, 0, 0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wait_wd(input int n);
        repeat (n) @(posedge wd_clk);
        #2;
    endtask

    task automatic do_reset(input logic strap);
        rst_n = 1'b0; hw_start = strap; wr_en = 1'b0;
        freeze_cfg = 1'b0; core_halted = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 100; i++) begin
            bus_read(2'd3, s);
            if (s[1:0] == 2'b00) break;
        end
    endtask

    task automatic configure(input int code, input int rld);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'(rld));
        wait_idle();
        bus_write(2'd1, 16'(code));
        wait_idle();
    endtask

    task automatic launch();
        bus_write(2'd0, 16'hCCCC);
        repeat (20) @(negedge clk);
    endtask

    task automatic timed_expiry(input int span, input string req);
        bus_write(2'd0, 16'hAAAA);
        if (span >= 2) begin
            wait_wd(span - 1);
            check(wd_reset == 1'b0, req, wd_reset, 0);
            wait_wd(9);
        end else begin
            wait_wd(span + 8);
        end
        check(wd_reset == 1'b1, req, wd_reset, 1);
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog timeout R1 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(1'b0);
        check(wd_reset == 1'b0, "R1 reset out", wd_reset, 0);
        check(clk_req == 1'b0, "R1 clk req", clk_req, 0);
        bus_read(2'd0, rv); check(rv == 16'h0, "R1 key reg", rv, 16'h0);
        bus_read(2'd1, rv); check(rv == 16'h0, "R1 div reg", rv, 16'h0);
        bus_read(2'd2, rv); check(rv == 16'hFFF, "R1 reload reg", rv, 16'hFFF);
        bus_read(2'd3, rv); check(rv == 16'h0, "R1 status", rv, 16'h0);

        // Table walk: R5 divider timing, R7 refresh load, R6 expiry, R10 halted without freeze enable
        for (int v = 0; v < NVEC; v++) begin
            int sh;
            do_reset(1'b0);
            core_halted = VHALT[v][0];
            configure(VCODE[v], VRLD[v]);
            launch();
            sh = (VCODE[v] > 6) ? 6 : VCODE[v];
            timed_expiry(VRLD[v] * (4 << sh), "R5 R7 R6 table vector");
        end

        // R6: reset output is sticky against refresh keys
        bus_write(2'd0, 16'hAAAA);
        wait_wd(40);
        check(wd_reset == 1'b1, "R6 sticky after refresh", wd_reset, 1);

        // R8: write protection
        do_reset(1'b0);
        bus_write(2'd2, 16'd5);
        bus_read(2'd2, rv); check(rv == 16'hFFF, "R8 locked write", rv, 16'hFFF);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd0, 16'h1234);
        bus_write(2'd2, 16'd5);
        bus_read(2'd2, rv); check(rv == 16'hFFF, "R8 relocked write", rv, 16'hFFF);
        bus_write(2'd0, 16'h5555);
        bus_write(2'd2, 16'd5);
        bus_read(2'd3, rv); check(rv == 16'h2, "R9 reload busy set", rv, 16'h2);
        bus_read(2'd2, rv); check(rv == 16'd5, "R8 unlocked write", rv, 16'd5);

        // R9: busy flags and writes while busy
        bus_write(2'd2, 16'd7);
        bus_read(2'd2, rv); check(rv == 16'd5, "R9 write while busy", rv, 16'd5);
        wait_idle();
        bus_read(2'd3, rv); check(rv == 16'h0, "R9 busy cleared", rv, 16'h0);
        bus_write(2'd1, 16'd2);
        bus_read(2'd3, rv); check(rv == 16'h1, "R9 divider busy set", rv, 16'h1);
        bus_write(2'd1, 16'd5);
        bus_read(2'd1, rv); check(rv == 16'd2, "R9 divider write while busy", rv, 16'd2);
        wait_idle();

        // R2: start key
        do_reset(1'b0);
        bus_write(2'd0, 16'hCCCC);
        check(clk_req == 1'b1, "R2 clk req after start", clk_req, 1);
        wait_wd(200);
        check(wd_reset == 1'b0, "R2 counts from 0xFFF", wd_reset, 0);

        // R3: strap launch without a start key
        do_reset(1'b1);
        repeat (2) @(negedge clk);
        check(clk_req == 1'b1, "R3 strap clk req", clk_req, 1);
        configure(0, 4);
        timed_expiry(16, "R3 strap running");
        hw_start = 1'b0;

        // R4: no key stops a running watchdog
        do_reset(1'b0);
        configure(0, 6);
        launch();
        bus_write(2'd0, 16'h0000);
        bus_write(2'd0, 16'h1234);
        bus_write(2'd0, 16'h5555);
        check(clk_req == 1'b1, "R4 clk req held", clk_req, 1);
        timed_expiry(24, "R4 still running");

        // R10: freeze holds the count
        do_reset(1'b0);
        configure(0, 10);
        freeze_cfg = 1'b1;
        core_halted = 1'b1;
        launch();
        bus_write(2'd0, 16'hAAAA);
        wait_wd(200);
        check(wd_reset == 1'b0, "R10 frozen no expiry", wd_reset, 0);
        @(negedge clk);
        core_halted = 1'b0;
        wait_wd(38);
        check(wd_reset == 1'b0, "R10 resumes from held value", wd_reset, 0);
        wait_wd(12);
        check(wd_reset == 1'b1, "R10 expiry after release", wd_reset, 1);
        freeze_cfg = 1'b0;

        // R7: refresh sweep so refreshes coincide with step-downs
        do_reset(1'b0);
        configure(0, 8);
        launch();
        for (int i = 0; i < 40; i++) begin
            bus_write(2'd0, 16'hAAAA);
            wait_wd(10 + (i * 5) % 17);
        end
        check(wd_reset == 1'b0, "R7 refresh sweep keeps alive", wd_reset, 0);
        timed_expiry(32, "R7 expiry after last refresh");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule